// File: doc/BRIEF.md
# Graphics Packet Tag Unpacker

This block sits on the inbound quadword stream of a graphics front end. Every packet starts with a 128-bit tag quadword. The tag gives a loop count, an end-of-packet flag, an optional primitive preset, a data format, a register count and a list of up to sixteen 4-bit register descriptors. In packed format, the block walks the data quadwords that follow the tag against that descriptor list. For each quadword it produces one register write: an 8-bit target address, a 64-bit payload, a skip-kick flag and a last flag.

The address-plus-data descriptor takes its target address from the quadword itself. The no-operation descriptor consumes a quadword but writes nothing. Register-list and image formats are not decoded. Each of their data quadwords is forwarded as one beat to a fixed pass-through address.

Both stream edges use valid/ready. An input quadword is accepted in a cycle where `in_valid` and `in_ready` are both high, and an output beat moves in a cycle where `out_valid` and `out_ready` are both high. The block has a single output register. `in_ready` is high only when that register is empty or is being emptied in the same cycle, so back-pressure on the output stalls the input at once. A beat held under back-pressure keeps all of its fields unchanged.

Top module: `pkt_tag_unpacker`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1, and the first accepted quadword is treated as a tag.
- R2: Tag fields are bits 14:0 loop count, bit 15 end-of-packet, bit 46 preset enable, bits 57:47 primitive, bits 59:58 format and bits 63:60 register count. A tag whose loop count is 0 takes no data quadwords, and the next accepted quadword is again a tag.
- R3: Descriptor k sits in tag bits 64+4k+3 down to 64+4k. A register count field of 0 means 16 descriptors.
- R4: In packed format (format 0), data quadword j of a tag uses descriptor j mod N, where N is the register count. The tag consumes exactly loop count times N data quadwords, and the quadword after them is a tag.
- R5: For descriptor 0xE, the beat carries address = quadword bits 71:64 and data = quadword bits 63:0.
- R6: For descriptor 0xF, the quadword is consumed and no beat is produced.
- R7: For any other descriptor d, the beat carries address = d zero-extended and data = bits 63:0. The skip flag equals quadword bit 111 when d is 4 or 5, and is 0 otherwise.
- R8: When a tag has preset enabled, accepting the tag produces one beat with address 0x00 and data = primitive field zero-extended, skip 0 and last 0. This happens even when the loop count is 0.
- R9: In formats 1, 2 and 3, each data quadword produces one beat with address `PASS_ADDR` (default 0xFF) and data = bits 63:0, and the loop count counts quadwords.
- R10: `out_last` is 1 only on the beat from the final data quadword of a tag whose end-of-packet bit is 1.
- R11: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and the beat stays unchanged.
- R12: A beat is presented in the cycle after the input quadword that produces it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input quadword valid |
| in_ready | output | 1 | Block can accept a quadword |
| in_data | input | 128 | Tag or data quadword |
| out_valid | output | 1 | Register write beat valid |
| out_ready | input | 1 | Consumer accepts the beat |
| out_addr | output | 8 | Target register address |
| out_data | output | 64 | Register payload |
| out_skip | output | 1 | Vertex must not trigger drawing |
| out_last | output | 1 | Final beat of the packet |

## Verification
A beat is due one cycle after the input quadword that produces it is accepted. In that cycle `out_valid` must be high. A beat held under back-pressure must be identical one cycle later. The bench drives inputs and `out_ready` just after the falling edge, then evaluates both handshakes 1 ns later, while the values are stable up to the next rising edge. The R12 check and the R11 check for a held beat are made at the falling edge after that rising edge, so every sample falls on the cycle in which the value is due. The expected beats come from a model that walks a sweep over formats, register counts, loop counts, preset and end-of-packet settings. That model is compared in order against the beats actually accepted.

// File: rtl/uq_pkg.sv
package uq_pkg;
  localparam int QW_W   = 128;
  localparam int DATA_W = 64;
  localparam int ADDR_W = 8;
  localparam int LOOP_W = 15;
  localparam int DESC_W = 4;
  localparam int DESC_N = 16;
  localparam int PRIM_W = 11;
  localparam int IDX_W  = $clog2(DESC_N);
  localparam int CNT_W  = IDX_W + 1;

  typedef enum logic [1:0] {
    FMT_PACKED = 2'd0,
    FMT_REGLST = 2'd1,
    FMT_IMG_A  = 2'd2,
    FMT_IMG_B  = 2'd3
  } fmt_e;

  typedef struct packed {
    logic [LOOP_W-1:0]        loops;
    logic                     eop;
    logic                     pre;
    logic [PRIM_W-1:0]        prim;
    fmt_e                     fmt;
    logic [CNT_W-1:0]         nreg;
    logic [DESC_N*DESC_W-1:0] regs;
  } tag_t;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic              skip;
    logic              last;
  } beat_t;
endpackage

// File: rtl/uq_tag_decode.sv
module uq_tag_decode
  import uq_pkg::*;
(
  input  logic [63:0]              ctl_half,
  input  logic [DESC_N*DESC_W-1:0] desc_half,
  output tag_t                     tag
);
  logic [3:0] cnt_field;
  logic       unused_ctl;

  assign cnt_field = ctl_half[63:60];
  assign unused_ctl = ^ctl_half[45:16];

  always_comb begin
    tag.loops = ctl_half[14:0];
    tag.eop   = ctl_half[15];
    tag.pre   = ctl_half[46];
    tag.prim  = ctl_half[57:47];
    tag.fmt   = fmt_e'(ctl_half[59:58]);
    // a zero count field stands for a full descriptor list
    tag.nreg  = (cnt_field == '0) ? CNT_W'(DESC_N) : {1'b0, cnt_field};
    tag.regs  = desc_half;
  end
endmodule

// File: rtl/uq_seq.sv
module uq_seq
  import uq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tag_fire,
  input  logic              data_fire,
  input  tag_t              tag,
  output logic              busy,
  output logic [DESC_W-1:0] desc,
  output fmt_e              fmt,
  output logic              eop,
  output logic              final_qw
);
  logic [LOOP_W-1:0]        loop_left;
  logic [IDX_W-1:0]         idx;
  logic [CNT_W-1:0]         nreg;
  logic [DESC_N*DESC_W-1:0] regs_q;
  logic [DESC_W-1:0]        nib [DESC_N];
  logic                     wrap;

  genvar g;
  generate
    for (g = 0; g < DESC_N; g++) begin : g_nib
      assign nib[g] = regs_q[g*DESC_W +: DESC_W];
    end
  endgenerate

  assign busy     = (loop_left != '0);
  assign desc     = nib[idx];
  assign wrap     = (fmt != FMT_PACKED) || ({1'b0, idx} == nreg - CNT_W'(1));
  assign final_qw = (loop_left == LOOP_W'(1)) && wrap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loop_left <= '0;
      idx       <= '0;
      nreg      <= CNT_W'(DESC_N);
      regs_q    <= '0;
      fmt       <= FMT_PACKED;
      eop       <= 1'b0;
    end else if (tag_fire) begin
      loop_left <= tag.loops;
      idx       <= '0;
      nreg      <= tag.nreg;
      regs_q    <= tag.regs;
      fmt       <= tag.fmt;
      eop       <= tag.eop;
    end else if (data_fire) begin
      if (wrap) begin
        idx       <= '0;
        loop_left <= loop_left - LOOP_W'(1);
      end else begin
        idx <= idx + IDX_W'(1);
      end
    end
  end

  // R3: the descriptor index never reaches the register count
  p_idx_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ({1'b0, idx} < nreg));
  // R3: a stored register count is never zero
  p_nreg_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    nreg != '0);
  // R4: a data quadword that ends the last loop returns to tag phase
  p_end_to_tag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_fire && final_qw) |=> !busy);
endmodule

// File: rtl/uq_route.sv
module uq_route
  import uq_pkg::*;
#(
  parameter logic [ADDR_W-1:0] PASS_ADDR = 8'hFF
) (
  input  logic              data_phase,
  input  tag_t              tag,
  input  fmt_e              fmt,
  input  logic [DESC_W-1:0] desc,
  input  logic              eop,
  input  logic              final_qw,
  input  logic [DATA_W-1:0] pay,
  input  logic [ADDR_W-1:0] ad_addr,
  input  logic              kick_bit,
  output logic              emit,
  output beat_t             beat
);
  localparam logic [DESC_W-1:0] D_AD  = 4'hE;
  localparam logic [DESC_W-1:0] D_NOP = 4'hF;
  localparam logic [DESC_W-1:0] D_XF  = 4'h4;
  localparam logic [DESC_W-1:0] D_X   = 4'h5;

  always_comb begin
    emit      = 1'b0;
    beat.addr = '0;
    beat.data = pay;
    beat.skip = 1'b0;
    beat.last = eop && final_qw;
    if (!data_phase) begin
      emit      = tag.pre;
      beat.data = DATA_W'(tag.prim);
      beat.last = 1'b0;
    end else if (fmt != FMT_PACKED) begin
      emit      = 1'b1;
      beat.addr = PASS_ADDR;
    end else if (desc == D_AD) begin
      emit      = 1'b1;
      beat.addr = ad_addr;
    end else if (desc != D_NOP) begin
      emit      = 1'b1;
      beat.addr = ADDR_W'(desc);
      beat.skip = ((desc == D_XF) || (desc == D_X)) && kick_bit;
    end
  end
endmodule

// File: rtl/pkt_tag_unpacker.sv
module pkt_tag_unpacker
  import uq_pkg::*;
#(
  parameter logic [7:0] PASS_ADDR = 8'hFF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [127:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [7:0]   out_addr,
  output logic [63:0]  out_data,
  output logic         out_skip,
  output logic         out_last
);
  tag_t              tag;
  logic              busy, eop, final_qw, emit;
  logic [DESC_W-1:0] desc;
  fmt_e              fmt;
  beat_t             rt_beat, out_q;
  logic              in_fire, tag_fire, data_fire, load;
  logic              unused_bits;

  assign unused_bits = ^{in_data[110:72], in_data[127:112]};

  assign in_ready  = !out_valid || out_ready;
  assign in_fire   = in_valid && in_ready;
  assign tag_fire  = in_fire && !busy;
  assign data_fire = in_fire && busy;
  assign load      = in_fire && emit;

  uq_tag_decode u_dec (
    .ctl_half  (in_data[63:0]),
    .desc_half (in_data[127:64]),
    .tag       (tag)
  );

  uq_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .tag_fire  (tag_fire),
    .data_fire (data_fire),
    .tag       (tag),
    .busy      (busy),
    .desc      (desc),
    .fmt       (fmt),
    .eop       (eop),
    .final_qw  (final_qw)
  );

  uq_route #(.PASS_ADDR(PASS_ADDR)) u_route (
    .data_phase (busy),
    .tag        (tag),
    .fmt        (fmt),
    .desc       (desc),
    .eop        (eop),
    .final_qw   (final_qw),
    .pay        (in_data[63:0]),
    .ad_addr    (in_data[71:64]),
    .kick_bit   (in_data[111]),
    .emit       (emit),
    .beat       (rt_beat)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_q     <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_q     <= rt_beat;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign out_addr = out_q.addr;
  assign out_data = out_q.data;
  assign out_skip = out_q.skip;
  assign out_last = out_q.last;

  // R11: a stalled beat holds, and the input is stalled with it
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) &&
                                   $stable(out_data) && $stable(out_last)));
  p_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
  // R12: a producing quadword yields a beat the next cycle
  p_latency_r12: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> out_valid);
  // R6: a no-op descriptor leaves the output empty
  p_nop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (data_fire && fmt == FMT_PACKED && desc == 4'hF) |=> !out_valid);
  // R8: a preset tag writes register zero
  p_preset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_fire && tag.pre) |=> (out_valid && out_addr == 8'h00 && !out_last));
  // R7: skip only on vertex registers
  p_skip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_skip) |-> (out_addr == 8'h04 || out_addr == 8'h05));
endmodule

// File: tb/pkt_tag_unpacker_tb_top.sv
module pkt_tag_unpacker_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] in_data = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [7:0]   out_addr;
  logic [63:0]  out_data;
  logic         out_skip;
  logic         out_last;

  always #4 clk = ~clk;

  pkt_tag_unpacker dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_data(out_data), .out_skip(out_skip),
    .out_last(out_last)
  );

  int checks = 0;
  int failures = 0;

  logic [127:0] in_q [$];
  bit           mk_q [$];
  logic [73:0]  exp_q [$];
  string        rq_q [$];
  int           qk = 0;

  function automatic logic [127:0] mkqw(int k);
    logic [127:0] q;
    q = {16'h6000 ^ 16'(k * 3), 32'hC0DE0000 + 32'(k), 32'h12345600 ^ 32'(k * 5), 32'h9E370000 + 32'(k * 11)};
    q[111] = k[0];
    return q;
  endfunction

  task automatic add_packet(int nloop, bit eop, bit pre, logic [10:0] prim,
                            logic [1:0] fmt, logic [3:0] nf, logic [63:0] regs);
    int nr;
    logic [127:0] q;
    logic [3:0] d;
    in_q.push_back({regs, nf, fmt, prim, pre, 30'h0, eop, 15'(nloop)});
    mk_q.push_back(pre);
    if (pre) begin exp_q.push_back({8'h00, 53'h0, prim, 1'b0, 1'b0}); rq_q.push_back("R8"); end
    nr = (nf == 0) ? 16 : int'(nf);
    for (int l = 0; l < nloop; l++) begin
      if (fmt != 2'd0) begin
        q = mkqw(qk); qk++;
        in_q.push_back(q); mk_q.push_back(1'b1);
        exp_q.push_back({8'hFF, q[63:0], 1'b0, eop && (l == nloop - 1)});
        rq_q.push_back("R9");
      end else begin
        for (int i = 0; i < nr; i++) begin
          d = regs[4*i +: 4];
          q = mkqw(qk); qk++;
          in_q.push_back(q);
          if (d == 4'hF) mk_q.push_back(1'b0);
          else begin
            mk_q.push_back(1'b1);
            if (d == 4'hE) begin
              exp_q.push_back({q[71:64], q[63:0], 1'b0, eop && l == nloop - 1 && i == nr - 1});
              rq_q.push_back("R5");
            end else begin
              exp_q.push_back({4'h0, d, q[63:0], (d == 4'h4 || d == 4'h5) && q[111],
                               eop && l == nloop - 1 && i == nr - 1});
              rq_q.push_back("R7");
            end
          end
        end
      end
    end
  endtask

  task automatic check(bit ok, string rq, string what, logic [73:0] act, logic [73:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, expv);
    end
  endtask

  initial begin
    logic [15:0] lfsr;
    logic [73:0] got, ex, held;
    string rq;
    int in_idx, cyc, total_beats, seen;
    bit chk_lat, hold_prev;
    logic [3:0] nfs [4];
    nfs = '{4'd1, 4'd2, 4'd3, 4'd0};
    // sweep: formats, register counts (incl. 0 meaning 16), loop counts 0..3
    for (int f = 0; f < 4; f++)
      for (int c = 0; c < 4; c++)
        for (int n = 0; n < 4; n++)
          add_packet(n, n[0] ^ c[0], (f + c + n) % 3 == 0, 11'(100 * f + 10 * c + n + 1),
                     2'(f), nfs[c],
                     {64'hFE54_3210_E45F_1E05} >> (4 * ((c + n + f) % 5)) |
                     (64'hE4F5_0000_0000_0000 >> (4 * n)));
    total_beats = exp_q.size();

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(out_valid == 1'b0 && in_ready == 1'b1, "R1", "reset state",
          {72'h0, out_valid, in_ready}, 74'h1);

    lfsr = 16'hACE1; in_idx = 0; cyc = 0; seen = 0; chk_lat = 0; hold_prev = 0; held = '0;
    while ((in_idx < in_q.size() || exp_q.size() > 0) && cyc < 100000) begin
      @(negedge clk);
      cyc++;
      got = {out_addr, out_data, out_skip, out_last};
      if (chk_lat) check(out_valid == 1'b1, "R12", "beat one cycle after accept", {73'h0, out_valid}, 74'h1);
      if (hold_prev) check(out_valid && got == held, "R11", "stalled beat held", got, held);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = lfsr[0] | lfsr[3];
      in_valid  = (in_idx < in_q.size()) && (lfsr[5] | lfsr[7]);
      in_data   = (in_idx < in_q.size()) ? in_q[in_idx] : '0;
      #1;
      hold_prev = out_valid && !out_ready;
      held = {out_addr, out_data, out_skip, out_last};
      if (hold_prev) check(!in_ready, "R11", "input stalled under back-pressure", {73'h0, in_ready}, 74'h0);
      if (out_valid && out_ready) begin
        seen++;
        if (exp_q.size() == 0) check(1'b0, "R6", "unexpected beat", held, '0);
        else begin
          ex = exp_q.pop_front(); rq = rq_q.pop_front();
          check(held[73:1] == ex[73:1], rq, "beat fields", held, ex);
          check(held[0] == ex[0], "R10", "last flag", held, ex);
        end
      end
      chk_lat = 1'b0;
      if (in_valid && in_ready) begin
        chk_lat = mk_q[in_idx];
        in_idx++;
      end
    end
    if (cyc >= 100000) check(1'b0, "R4", "watchdog expired", 74'(cyc), 74'h0);
    // R2 R3 R4 R6: whole stream consumed and beat count matches the model
    check(seen == total_beats && exp_q.size() == 0, "R4", "beat count (R2 R3 R6)",
          74'(seen), 74'(total_beats));
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule